// File: doc/BRIEF.md
# Speculative Register File with Checkpoint and Not-Ready Tracking

This block holds the architectural integer registers of a core that keeps running past a long-latency instruction. Each register exists twice. The working copy takes every write. The checkpoint copy follows the working copy while no speculation is active. It stops following at the moment a checkpoint is taken, with no added cycle. Each working register also has a not-ready bit. A write sets the bit when at least one of its source operands is flagged not-ready, and clears it otherwise.

A speculative episode ends in one of two ways:
- **Fail:** every working register gets its checkpoint value back, all not-ready bits clear, and execution returns to the point right after the checkpoint.
- **Join:** the working state is kept and becomes the new committed state, again with no added cycle.

Instructions deferred because of a not-ready operand write back later through a separate port. Every write is stamped with a sequence tag, and the last tag is kept per register. A deferred result lands only if its register is still not-ready and still holds that tag. An older result therefore never overwrites a younger one.

The not-ready bit of a designated condition-code register is brought out. Branch logic uses it to decide when to rely on a prediction.

Top module: `ckpt_regfile`

## Requirements
- R1: After reset, every working register and every checkpoint register reads 0, every not-ready bit is 0, and no speculation is active.
- R2: A write with `wr_en_i` high updates the working register at `wr_addr_i`. The value shows on a read port from the cycle after the clock edge. Read port k takes its address from `rd_addr_i[k*AW +: AW]` and returns data on `rd_data_o[k*DATA_W +: DATA_W]`.
- R3: A write sets the destination's not-ready bit to the OR of all `wr_src_nr_i` bits. The bit is visible on `rd_nr_o[k]` for read port k.
- R4: A checkpoint request while idle starts speculation. The checkpoint copy keeps the working values from just before that clock edge. A write in the same cycle as the request is speculative.
- R5: A checkpoint request while speculation is active is ignored. It changes neither the frozen copy nor the active state.
- R6: A fail while active restores every working register from the checkpoint copy, clears every not-ready bit and ends speculation. A write or deferred writeback in the same cycle is discarded. A fail while idle has no effect.
- R7: A join while active keeps all working values and ends speculation. From then on the checkpoint copy follows the working copy again, so a later fail restores the joined values.
- R8: A deferred writeback updates the working data and clears the not-ready bit only if that register is not-ready and its stored tag equals `dwb_tag_i`. Otherwise it changes nothing. An ordinary write to the same register in the same cycle takes precedence.
- R9: `wr_tag_o` shows the tag that the next write will store. It starts at 0 and steps by one (modulo 2^TAG_W) on every cycle with `wr_en_i` high.
- R10: `cc_pred_o` equals the not-ready bit of register `CC_REG`.
- R11: When join and fail arrive in the same active cycle, the fail wins.
- R12: `spec_active_o` is high exactly while a checkpoint is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ckpt_i | input | 1 | Take a checkpoint |
| join_i | input | 1 | Commit the speculative state |
| fail_i | input | 1 | Discard the speculative state |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | AW | Write destination |
| wr_data_i | input | DATA_W | Write data |
| wr_src_nr_i | input | NUM_SRC | Not-ready flags of the sources |
| wr_tag_o | output | TAG_W | Tag stored by the next write |
| dwb_en_i | input | 1 | Deferred writeback strobe |
| dwb_addr_i | input | AW | Deferred writeback destination |
| dwb_data_i | input | DATA_W | Deferred writeback data |
| dwb_tag_i | input | TAG_W | Tag of the deferred writer |
| rd_addr_i | input | NUM_RD*AW | Read addresses, one field per port |
| rd_data_o | output | NUM_RD*DATA_W | Working read data |
| rd_nr_o | output | NUM_RD | Not-ready bit per read port |
| cc_pred_o | output | 1 | Condition-code register is not-ready |
| spec_active_o | output | 1 | Checkpoint held |

## Verification
The bench builds the block with 8 registers of 16 bits, a 4-bit tag, two read ports, two source flags and register 7 as the condition-code register.

With only eight registers, random writes and deferred writebacks hit the same register often. This exercises both outcomes of the tag comparison, including stale tags.

A 4-bit tag wraps within a few dozen writes, so the random run also covers tag values after wrap-around.

Checkpoint, join and fail requests come often enough that the run repeatedly sees:
- nested checkpoint requests,
- join and fail arriving together,
- fails issued while idle.

// File: rtl/ckpt_rf_pkg.sv
package ckpt_rf_pkg;
  typedef struct packed {
    logic fail;    // restore from checkpoint this edge
    logic join_c;  // commit this edge
    logic mirror;  // checkpoint copy follows working copy
  } ckpt_ctl_t;
endpackage

// File: rtl/ckpt_rf_ctrl.sv
module ckpt_rf_ctrl
  import ckpt_rf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ckpt_i,
  input  logic      join_i,
  input  logic      fail_i,
  output ckpt_ctl_t ctl_o,
  output logic      active_o
);
  logic act_q;
  logic take;

  assign take          = ckpt_i & ~act_q;
  assign ctl_o.fail    = fail_i & act_q;
  assign ctl_o.join_c  = join_i & act_q & ~fail_i;
  assign ctl_o.mirror  = (~act_q & ~ckpt_i) | ctl_o.join_c;
  assign active_o      = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         act_q <= 1'b0;
    else if (ctl_o.fail || ctl_o.join_c) act_q <= 1'b0;
    else if (take)                       act_q <= 1'b1;
  end

  a_r12_take_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q && ckpt_i |=> act_q);
  a_r5_nested_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && ckpt_i && !join_i && !fail_i |=> act_q);
  a_r11_fail_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && fail_i && join_i |=> !act_q);
  a_r11_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_o.fail && ctl_o.join_c));
endmodule

// File: rtl/ckpt_rf_nr.sv
module ckpt_rf_nr #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 6,
  parameter int NUM_RD   = 2,
  parameter int NUM_SRC  = 2,
  parameter int CC_REG   = 31,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fail_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [NUM_SRC-1:0]   wr_src_nr_i,
  output logic [TAG_W-1:0]     wr_tag_o,
  input  logic                 dwb_en_i,
  input  logic [AW-1:0]        dwb_addr_i,
  input  logic [TAG_W-1:0]     dwb_tag_i,
  output logic                 dwb_hit_o,
  input  logic [NUM_RD*AW-1:0] rd_addr_i,
  output logic [NUM_RD-1:0]    rd_nr_o,
  output logic                 cc_nr_o
);
  logic [NUM_REGS-1:0]            nr_q;
  logic [NUM_REGS-1:0][TAG_W-1:0] tag_q;
  logic [TAG_W-1:0]               seq_q;

  assign wr_tag_o  = seq_q;
  assign cc_nr_o   = nr_q[CC_REG];
  assign dwb_hit_o = dwb_en_i & ~fail_i & nr_q[dwb_addr_i]
                   & (tag_q[dwb_addr_i] == dwb_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seq_q <= '0;
    else if (wr_en_i) seq_q <= seq_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic wr_hit, dwb_sel;
    assign wr_hit  = wr_en_i & (wr_addr_i == AW'(i));
    assign dwb_sel = dwb_hit_o & (dwb_addr_i == AW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nr_q[i]  <= 1'b0;
        tag_q[i] <= '0;
      end else begin
        if (fail_i)       nr_q[i] <= 1'b0;
        else if (wr_hit)  nr_q[i] <= |wr_src_nr_i;
        else if (dwb_sel) nr_q[i] <= 1'b0;
        if (wr_hit) tag_q[i] <= seq_q;
      end
    end
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    assign rd_nr_o[k] = nr_q[rd_addr_i[k*AW +: AW]];
  end

  a_r3_nr_propagates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !fail_i |=> nr_q[$past(wr_addr_i)] == $past(|wr_src_nr_i));
  a_r6_fail_clears_nr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> nr_q == '0);
  a_r8_stale_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwb_en_i && !fail_i && !(wr_en_i && wr_addr_i == dwb_addr_i)
      && tag_q[dwb_addr_i] != dwb_tag_i
    |=> nr_q[$past(dwb_addr_i)] == $past(nr_q[dwb_addr_i]));
  a_r9_tag_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> seq_q == $past(seq_q) + 1'b1);
endmodule

// File: rtl/ckpt_rf_bank.sv
module ckpt_rf_bank
  import ckpt_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 2,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  ckpt_ctl_t                ctl_i,
  input  logic                     active_i,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     dwb_hit_i,
  input  logic [AW-1:0]            dwb_addr_i,
  input  logic [DATA_W-1:0]        dwb_data_i,
  input  logic [NUM_RD*AW-1:0]     rd_addr_i,
  output logic [NUM_RD*DATA_W-1:0] rd_data_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] work_q, work_nx, ckpt_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_comb begin
      if (ctl_i.fail)                                 work_nx[i] = ckpt_q[i];
      else if (wr_en_i && wr_addr_i == AW'(i))        work_nx[i] = wr_data_i;
      else if (dwb_hit_i && dwb_addr_i == AW'(i))     work_nx[i] = dwb_data_i;
      else                                            work_nx[i] = work_q[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        work_q[i] <= '0;
        ckpt_q[i] <= '0;
      end else begin
        work_q[i] <= work_nx[i];
        if (ctl_i.mirror) ckpt_q[i] <= work_nx[i];
      end
    end
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    assign rd_data_o[k*DATA_W +: DATA_W] = work_q[rd_addr_i[k*AW +: AW]];
  end

  a_r4_ckpt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !ctl_i.join_c |=> ckpt_q == $past(ckpt_q));
  a_r6_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.fail |=> work_q == $past(ckpt_q));
  a_r7_join_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.join_c |=> ckpt_q == work_q);
endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
  import ckpt_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 6,
  parameter int NUM_RD   = 2,
  parameter int NUM_SRC  = 2,
  parameter int CC_REG   = 31,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ckpt_i,
  input  logic                     join_i,
  input  logic                     fail_i,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [NUM_SRC-1:0]       wr_src_nr_i,
  output logic [TAG_W-1:0]         wr_tag_o,
  input  logic                     dwb_en_i,
  input  logic [AW-1:0]            dwb_addr_i,
  input  logic [DATA_W-1:0]        dwb_data_i,
  input  logic [TAG_W-1:0]         dwb_tag_i,
  input  logic [NUM_RD*AW-1:0]     rd_addr_i,
  output logic [NUM_RD*DATA_W-1:0] rd_data_o,
  output logic [NUM_RD-1:0]        rd_nr_o,
  output logic                     cc_pred_o,
  output logic                     spec_active_o
);
  ckpt_ctl_t ctl;
  logic      active;
  logic      dwb_hit;

  assign spec_active_o = active;

  ckpt_rf_ctrl u_ctrl (
    .clk_i, .rst_ni, .ckpt_i, .join_i, .fail_i,
    .ctl_o(ctl), .active_o(active)
  );

  ckpt_rf_nr #(
    .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .NUM_RD(NUM_RD),
    .NUM_SRC(NUM_SRC), .CC_REG(CC_REG)
  ) u_nr (
    .clk_i, .rst_ni, .fail_i(ctl.fail),
    .wr_en_i, .wr_addr_i, .wr_src_nr_i, .wr_tag_o,
    .dwb_en_i, .dwb_addr_i, .dwb_tag_i, .dwb_hit_o(dwb_hit),
    .rd_addr_i, .rd_nr_o, .cc_nr_o(cc_pred_o)
  );

  ckpt_rf_bank #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD)
  ) u_bank (
    .clk_i, .rst_ni, .ctl_i(ctl), .active_i(active),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .dwb_hit_i(dwb_hit), .dwb_addr_i, .dwb_data_i,
    .rd_addr_i, .rd_data_o
  );
endmodule

// File: tb/sim_ckpt_regfile.sv
module sim_ckpt_regfile;
  localparam int NR = 8, DW = 16, TW = 4, NRD = 2, NS = 2, CC = 7, AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ck = 0, jn = 0, fl = 0, we = 0, de = 0;
  logic [AW-1:0] wa = '0, da = '0;
  logic [DW-1:0] wd = '0, dd = '0;
  logic [NS-1:0] src = '0;
  logic [TW-1:0] dt = '0, wtag;
  logic [NRD*AW-1:0] ra = '0;
  logic [NRD*DW-1:0] rdat;
  logic [NRD-1:0] rnr;
  logic ccp, act;

  always #5ns clk = ~clk;

  ckpt_regfile #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW), .NUM_RD(NRD),
                 .NUM_SRC(NS), .CC_REG(CC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ckpt_i(ck), .join_i(jn), .fail_i(fl),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .wr_src_nr_i(src),
    .wr_tag_o(wtag), .dwb_en_i(de), .dwb_addr_i(da), .dwb_data_i(dd),
    .dwb_tag_i(dt), .rd_addr_i(ra), .rd_data_o(rdat), .rd_nr_o(rnr),
    .cc_pred_o(ccp), .spec_active_o(act));

  logic [DW-1:0] m_work [NR], m_ckpt [NR];
  logic          m_nr [NR];
  logic [TW-1:0] m_tag [NR];
  logic [TW-1:0] m_seq;
  logic          m_act;
  int n_vec = 0, n_err = 0;

  task automatic chk(string req, logic [31:0] a, logic [31:0] e);
    n_vec++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic model_step();
    logic [DW-1:0] nw [NR];
    logic          nn [NR];
    logic e_fail, e_join, mir;
    e_fail = fl && m_act;
    e_join = jn && m_act && !fl;
    mir    = (!m_act && !ck) || e_join;
    nw = m_work; nn = m_nr;
    if (de && m_nr[da] && m_tag[da] == dt) begin nw[da] = dd; nn[da] = 1'b0; end
    if (we) begin
      nw[wa] = wd; nn[wa] = |src; m_tag[wa] = m_seq; m_seq = m_seq + 1'b1;
    end
    if (e_fail) begin
      nw = m_ckpt;
      for (int i = 0; i < NR; i++) nn[i] = 1'b0;
    end
    if (mir) m_ckpt = nw;
    m_work = nw; m_nr = nn;
    if (e_fail || e_join) m_act = 1'b0;
    else if (ck && !m_act) m_act = 1'b1;
  endtask

  task automatic cyc();
    if (we) chk("R9 tag", 32'(wtag), 32'(m_seq));
    @(posedge clk);
    model_step();
    #1;
    ck = 0; jn = 0; fl = 0; we = 0; de = 0; src = '0;
  endtask

  task automatic check_all(string req);
    for (int r = 0; r < NR; r++) begin
      ra[0 +: AW]  = AW'(r);
      ra[AW +: AW] = AW'((r + 3) % NR);
      #1;
      chk({req, " data p0"}, 32'(rdat[0 +: DW]), 32'(m_work[r]));
      chk({req, " nr p0"}, 32'(rnr[0]), 32'(m_nr[r]));
      chk({req, " data p1"}, 32'(rdat[DW +: DW]), 32'(m_work[(r + 3) % NR]));
    end
    chk("R10 cc", 32'(ccp), 32'(m_nr[CC]));
    chk("R12 active", 32'(act), 32'(m_act));
  endtask

  task automatic wr(int a, int d, int s);
    we = 1; wa = AW'(a); wd = DW'(d); src = NS'(s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [TW-1:0] t1, t2;
    for (int i = 0; i < NR; i++) begin
      m_work[i] = '0; m_ckpt[i] = '0; m_nr[i] = 0; m_tag[i] = '0;
    end
    m_seq = '0; m_act = 0;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    check_all("R1 reset");
    chk("R9 tag reset", 32'(wtag), 0);

    wr(1, 'h1234, 0); cyc();
    wr(2, 'h0bad, 1); cyc();
    wr(CC, 'h00cc, 2); cyc();
    check_all("R2 R3 R10");

    wr(3, 'haaaa, 0); cyc();
    ck = 1; wr(3, 'hbbbb, 0); cyc();
    chk("R12 started", 32'(act), 1);
    wr(3, 'hcccc, 1); cyc();
    check_all("R4 spec");
    fl = 1; cyc();
    check_all("R4 R6 restore");
    ra[0 +: AW] = 3; #1;
    chk("R4 frozen value", 32'(rdat[0 +: DW]), 'haaaa);
    chk("R6 nr cleared", 32'(ccp), 0);

    fl = 1; wr(4, 'h0404, 0); cyc();
    check_all("R6 idle fail");

    ck = 1; cyc();
    wr(4, 'h1111, 0); cyc();
    ck = 1; wr(4, 'h2222, 0); cyc();
    fl = 1; cyc();
    ra[0 +: AW] = 4; #1;
    chk("R5 nested ignored", 32'(rdat[0 +: DW]), 'h0404);

    ck = 1; cyc();
    wr(5, 'h5555, 0); cyc();
    jn = 1; cyc();
    chk("R7 inactive", 32'(act), 0);
    ck = 1; cyc();
    wr(5, 'h6666, 0); cyc();
    fl = 1; cyc();
    ra[0 +: AW] = 5; #1;
    chk("R7 joined kept", 32'(rdat[0 +: DW]), 'h5555);

    ck = 1; cyc();
    wr(6, 'h6060, 0); cyc();
    jn = 1; fl = 1; cyc();
    ra[0 +: AW] = 6; #1;
    chk("R11 fail wins", 32'(rdat[0 +: DW]), 0);
    check_all("R11");

    ck = 1; cyc();
    t1 = wtag; wr(2, 'h2001, 1); cyc();
    t2 = wtag; wr(2, 'h2002, 1); cyc();
    de = 1; da = 2; dd = 'hdead; dt = t1; cyc();
    ra[0 +: AW] = 2; #1;
    chk("R8 stale data", 32'(rdat[0 +: DW]), 'h2002);
    chk("R8 stale nr", 32'(rnr[0]), 1);
    de = 1; da = 2; dd = 'hbeef; dt = t2; cyc();
    #1;
    chk("R8 hit data", 32'(rdat[0 +: DW]), 'hbeef);
    chk("R8 hit nr", 32'(rnr[0]), 0);
    de = 1; da = 2; dd = 'h7777; dt = t2; cyc();
    #1;
    chk("R8 ready ignored", 32'(rdat[0 +: DW]), 'hbeef);
    jn = 1; cyc();
    check_all("R8 R7");

    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 99);
      ck = (r < 8);
      jn = (r >= 8 && r < 13) || (r >= 96);
      fl = (r >= 13 && r < 17) || (r >= 96);
      we = $urandom_range(0, 3) != 0;
      wa = AW'($urandom); wd = DW'($urandom);
      src = ($urandom_range(0, 2) == 0) ? NS'($urandom) : '0;
      de = $urandom_range(0, 2) == 0;
      da = AW'($urandom); dd = DW'($urandom);
      dt = $urandom_range(0, 1) ? m_tag[da] : TW'($urandom);
      cyc();
      check_all("R2 R3 R6 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule